// File: doc/BRIEF.md
# Indirect Register Access over SPI with Write Unlock

This block is a serial slave that takes 32-bit frames from an SPI master (mode 0, most significant bit first, chip select active low) and turns each one into a single access to a small internal register file. One frame carries everything: a flag that chooses write or read, a 7-bit register address and a 16-bit data value. The answer to a read comes back on MISO during the next frame.

All writes, except those to the unlock register, are refused until the master has written two key words to the unlock register in the right order. The unlock progress can be read back. The register file holds a 10-bit dwell time, a 16-bit interface control word, three 64-bit lookup matrices and two read-only values. Each matrix is reached as four 16-bit words. The read-only values are the live input status and a revision number. The serial pins are sampled by the system clock through synchronizers, so the serial clock must be several times slower than `clk`.

Top module: `spi_reg_access`

## Requirements
- R1: A command runs once, after exactly 32 bits have been clocked in on rising SCLK edges while CS_N is low. Bit 31 set means write, bits 30..24 are the address and bits 15..0 are the data. Bits after the 32nd in the same frame are ignored. A frame that ends before 32 bits does nothing, and the next frame starts counting again from bit 31.
- R2: A command whose bits 23..16 are not all zero is dropped. It writes nothing, changes no unlock state, and its response word is zero.
- R3: The response is shifted out on MISO during the next frame, MSB first, with MISO changing after falling SCLK edges. Bits 31..16 are always zero. Bits 15..0 carry the read data for a read command, and are zero for a write command or a dropped command.
- R4: After reset the unlock state is 0x0000, all writable registers are zero and MISO is low.
- R5: Writing 0xA569 to address 0x00 sets the unlock state to 0x0001, whatever the state was before.
- R6: Writing 0x1248 to address 0x00 while the state is 0x0001 sets the state to 0x0003, which enables writes to other registers.
- R7: Any other write to address 0x00 sets the state to 0x0000. This includes writing 0x1248 while the state is not 0x0001.
- R8: A read of address 0x00 returns the unlock state, which is always one of 0x0000, 0x0001 or 0x0003.
- R9: While the state is not 0x0003, writes to any address other than 0x00 change nothing.
- R10: Address 0x01 keeps only bits 9..0 of the written data. It drives `dwell_time` and reads back with bits 15..10 as zero.
- R11: Address 0x02 is a 16-bit read/write control word that drives `iface_ctrl`.
- R12: Addresses 0x08–0x0B hold the alarm matrix, 0x0C–0x0F the error matrix and 0x10–0x13 the LED matrix. The word at base+k holds matrix bits 16k+15..16k, and each matrix drives its own output.
- R13: Address 0x03 reads `status_in` and address 0x7F reads the revision parameter. Writes to either address have no effect. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial command data |
| spi_miso | output | 1 | Serial response data, low when not selected |
| status_in | input | 16 | Live status presented at address 0x03 |
| dwell_time | output | 10 | Dwell time register |
| iface_ctrl | output | 16 | Interface control register |
| alarm_matrix | output | 64 | Alarm pattern matrix |
| error_matrix | output | 64 | Error indicator matrix |
| led_matrix | output | 64 | LED indicator matrix |

## Verification
The hardest states to reach from the pins are the unlock transitions that depend on history. These are a first key written while already unlocked, and a second key written while locked or while already open. Each needs an exact sequence of whole frames, and its result can only be seen through a later read frame. The bench walks these sequences one after another and reads the state back after every step. Frame-length corner cases are reached by driving CS_N around partial frames and overlong frames. After each one, a normal frame checks that the bit counter started again from zero.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;
    localparam int FRAME_BITS = 32;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 16;
    localparam int RSV_W      = FRAME_BITS - 1 - ADDR_W - DATA_W;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 16'hA569;
    localparam logic [DATA_W-1:0] KEY_SECOND = 16'h1248;

    localparam logic [ADDR_W-1:0] ADDR_UNLOCK   = 7'h00;
    localparam logic [ADDR_W-1:0] ADDR_DWELL    = 7'h01;
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 7'h02;
    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 7'h03;
    localparam logic [ADDR_W-1:0] ADDR_MAT_BASE = 7'h08;
    localparam logic [ADDR_W-1:0] ADDR_REV      = 7'h7F;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'b00,
        UL_HALF   = 2'b01,
        UL_OPEN   = 2'b11
    } unlock_e;
endpackage

// File: rtl/spi_ra_link.sv
module spi_ra_link #(
    parameter int FRAME_BITS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    output logic                  miso,
    output logic                  cmd_valid,
    output logic [FRAME_BITS-1:0] cmd_word,
    input  logic [FRAME_BITS-1:0] resp_word
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [SYNC_STAGES:0]   sclk_sh;
        logic [SYNC_STAGES:0]   cs_sh;
        logic [SYNC_STAGES-1:0] mosi_sh;
        logic [CNT_W-1:0]       cnt;
        logic [FRAME_BITS-1:0]  rx;
        logic [FRAME_BITS-1:0]  tx;
        logic [FRAME_BITS-1:0]  pend;
        logic                   done;
    } link_t;

    link_t link_d, link_q;

    logic sclk_now, sclk_prev, cs_idle, cs_was_idle, mosi_now;
    assign sclk_now    = link_q.sclk_sh[SYNC_STAGES-1];
    assign sclk_prev   = link_q.sclk_sh[SYNC_STAGES];
    assign cs_idle     = link_q.cs_sh[SYNC_STAGES-1];
    assign cs_was_idle = link_q.cs_sh[SYNC_STAGES];
    assign mosi_now    = link_q.mosi_sh[SYNC_STAGES-1];

    always_comb begin
        link_d         = link_q;
        link_d.done    = 1'b0;
        link_d.sclk_sh = {link_q.sclk_sh[SYNC_STAGES-1:0], sclk};
        link_d.cs_sh   = {link_q.cs_sh[SYNC_STAGES-1:0], cs_n};
        link_d.mosi_sh = {link_q.mosi_sh[SYNC_STAGES-2:0], mosi};
        if (cs_idle) begin
            link_d.cnt = '0;
        end else if (cs_was_idle) begin
            link_d.cnt = '0;
            link_d.tx  = link_q.pend;
        end else begin
            if (sclk_now && !sclk_prev && link_q.cnt < FULL_CNT) begin
                link_d.rx  = {link_q.rx[FRAME_BITS-2:0], mosi_now};
                link_d.cnt = link_q.cnt + 1'b1;
                if (link_q.cnt == LAST_BIT) begin
                    link_d.done = 1'b1;
                end
            end
            if (!sclk_now && sclk_prev) begin
                link_d.tx = {link_q.tx[FRAME_BITS-2:0], 1'b0};
            end
        end
        if (link_q.done) begin
            link_d.pend = resp_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q       <= '0;
            link_q.cs_sh <= '1;
        end else begin
            link_q <= link_d;
        end
    end

    assign miso      = !cs_idle && link_q.tx[FRAME_BITS-1];
    assign cmd_valid = link_q.done;
    assign cmd_word  = link_q.rx;
endmodule

// File: rtl/spi_ra_unlock.sv
module spi_ra_unlock
    import spi_ra_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output unlock_e           state,
    output logic              unlocked
);
    typedef struct packed {
        unlock_e st;
    } ul_t;

    ul_t ul_d, ul_q;

    always_comb begin
        ul_d = ul_q;
        if (key_wr) begin
            if (key_data == KEY_FIRST) begin
                ul_d.st = UL_HALF;
            end else if (key_data == KEY_SECOND && ul_q.st == UL_HALF) begin
                ul_d.st = UL_OPEN;
            end else begin
                ul_d.st = UL_LOCKED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ul_q.st <= UL_LOCKED;
        end else begin
            ul_q <= ul_d;
        end
    end

    assign state    = ul_q.st;
    assign unlocked = (ul_q.st == UL_OPEN);
endmodule

// File: rtl/spi_ra_regs.sv
module spi_ra_regs
    import spi_ra_pkg::*;
#(
    parameter int                MAT_BITS = 64,
    parameter int                NUM_MAT  = 3,
    parameter int                DWELL_W  = 10,
    parameter logic [DATA_W-1:0] REVISION = 16'h0102
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [DATA_W-1:0]           status_in,
    input  logic [DATA_W-1:0]           unlock_word,
    output logic [DATA_W-1:0]           rd_data,
    output logic [DWELL_W-1:0]          dwell_out,
    output logic [DATA_W-1:0]           ctrl_out,
    output logic [NUM_MAT*MAT_BITS-1:0] mat_out
);
    localparam int WORDS  = MAT_BITS / DATA_W;
    localparam int NWORDS = NUM_MAT * WORDS;

    typedef struct packed {
        logic [DWELL_W-1:0]             dwell;
        logic [DATA_W-1:0]              ctrl;
        logic [NWORDS-1:0][DATA_W-1:0]  mat;
    } regs_t;

    regs_t rf_d, rf_q;

    logic [ADDR_W-1:0] mat_off;
    logic              in_mat;
    assign mat_off = addr - ADDR_MAT_BASE;
    assign in_mat  = (addr >= ADDR_MAT_BASE) && (mat_off < ADDR_W'(NWORDS));

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            if (addr == ADDR_DWELL) begin
                rf_d.dwell = wr_data[DWELL_W-1:0];
            end
            if (addr == ADDR_CTRL) begin
                rf_d.ctrl = wr_data;
            end
            for (int w = 0; w < NWORDS; w++) begin
                if (in_mat && mat_off == ADDR_W'(w)) begin
                    rf_d.mat[w] = wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_UNLOCK) begin
            rd_data = unlock_word;
        end else if (addr == ADDR_DWELL) begin
            rd_data = DATA_W'(rf_q.dwell);
        end else if (addr == ADDR_CTRL) begin
            rd_data = rf_q.ctrl;
        end else if (addr == ADDR_STATUS) begin
            rd_data = status_in;
        end else if (addr == ADDR_REV) begin
            rd_data = REVISION;
        end else if (in_mat) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (mat_off == ADDR_W'(w)) begin
                    rd_data = rf_q.mat[w];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign dwell_out = rf_q.dwell;
    assign ctrl_out  = rf_q.ctrl;

    for (genvar w = 0; w < NWORDS; w++) begin : g_mat_word
        assign mat_out[w*DATA_W +: DATA_W] = rf_q.mat[w];
    end
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
    import spi_ra_pkg::*;
#(
    parameter int                MAT_BITS    = 64,
    parameter int                DWELL_W     = 10,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] REVISION    = 16'h0102
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sclk,
    input  logic                spi_cs_n,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [DATA_W-1:0]   status_in,
    output logic [DWELL_W-1:0]  dwell_time,
    output logic [DATA_W-1:0]   iface_ctrl,
    output logic [MAT_BITS-1:0] alarm_matrix,
    output logic [MAT_BITS-1:0] error_matrix,
    output logic [MAT_BITS-1:0] led_matrix
);
    localparam int NUM_MAT = 3;

    logic                  cmd_valid;
    logic [FRAME_BITS-1:0] cmd_word;
    logic [FRAME_BITS-1:0] resp_word;
    logic                  cmd_write;
    logic [ADDR_W-1:0]     cmd_addr;
    logic [RSV_W-1:0]      cmd_rsv;
    logic [DATA_W-1:0]     cmd_data;
    logic                  rsv_ok;
    logic                  key_wr;
    logic                  reg_wr;
    unlock_e               unlock_state;
    logic                  unlocked;
    logic [DATA_W-1:0]     rd_data;
    logic [NUM_MAT*MAT_BITS-1:0] mat_all;

    assign cmd_write = cmd_word[FRAME_BITS-1];
    assign cmd_addr  = cmd_word[FRAME_BITS-2 -: ADDR_W];
    assign cmd_rsv   = cmd_word[DATA_W +: RSV_W];
    assign cmd_data  = cmd_word[DATA_W-1:0];
    assign rsv_ok    = (cmd_rsv == '0);

    assign key_wr = cmd_valid && rsv_ok && cmd_write && (cmd_addr == ADDR_UNLOCK);
    assign reg_wr = cmd_valid && rsv_ok && cmd_write && unlocked && (cmd_addr != ADDR_UNLOCK);

    always_comb begin
        resp_word = '0;
        if (rsv_ok && !cmd_write) begin
            resp_word[DATA_W-1:0] = rd_data;
        end
    end

    spi_ra_link #(
        .FRAME_BITS  (FRAME_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .miso      (spi_miso),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .resp_word (resp_word)
    );

    spi_ra_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (cmd_data),
        .state    (unlock_state),
        .unlocked (unlocked)
    );

    spi_ra_regs #(
        .MAT_BITS (MAT_BITS),
        .NUM_MAT  (NUM_MAT),
        .DWELL_W  (DWELL_W),
        .REVISION (REVISION)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .addr        (cmd_addr),
        .wr_data     (cmd_data),
        .status_in   (status_in),
        .unlock_word ({{(DATA_W-2){1'b0}}, unlock_state}),
        .rd_data     (rd_data),
        .dwell_out   (dwell_time),
        .ctrl_out    (iface_ctrl),
        .mat_out     (mat_all)
    );

    assign alarm_matrix = mat_all[0*MAT_BITS +: MAT_BITS];
    assign error_matrix = mat_all[1*MAT_BITS +: MAT_BITS];
    assign led_matrix   = mat_all[2*MAT_BITS +: MAT_BITS];
endmodule

// File: rtl/spi_reg_access_chk.sv
module spi_reg_access_chk
    import spi_ra_pkg::*;
#(
    parameter int MAT_BITS = 64,
    parameter int DWELL_W  = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic                cmd_write,
    input logic [ADDR_W-1:0]   cmd_addr,
    input logic [DATA_W-1:0]   cmd_data,
    input logic                rsv_ok,
    input logic [1:0]          unlock_state,
    input logic [DWELL_W-1:0]  dwell_time,
    input logic [DATA_W-1:0]   iface_ctrl,
    input logic [MAT_BITS-1:0] alarm_matrix,
    input logic [MAT_BITS-1:0] error_matrix,
    input logic [MAT_BITS-1:0] led_matrix
);
    logic key_cmd;
    assign key_cmd = cmd_valid && rsv_ok && cmd_write && (cmd_addr == ADDR_UNLOCK);

    // R1: one command per completed frame
    assert_single_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_reserved_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsv_ok) |=> ($stable(unlock_state) && $stable(iface_ctrl)
            && $stable(dwell_time) && $stable(alarm_matrix)
            && $stable(error_matrix) && $stable(led_matrix)));

    assert_first_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_cmd && cmd_data == KEY_FIRST) |=> (unlock_state == 2'b01));

    assert_second_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_cmd && cmd_data == KEY_SECOND && unlock_state == 2'b01) |=> (unlock_state == 2'b11));

    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_cmd && cmd_data != KEY_FIRST && !(cmd_data == KEY_SECOND && unlock_state == 2'b01))
            |=> (unlock_state == 2'b00));

    assert_state_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_state != 2'b10);

    assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && unlock_state != 2'b11)
            |=> ($stable(iface_ctrl) && $stable(dwell_time) && $stable(alarm_matrix)
                && $stable(error_matrix) && $stable(led_matrix)));
endmodule

bind spi_reg_access spi_reg_access_chk #(
    .MAT_BITS (MAT_BITS),
    .DWELL_W  (DWELL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data),
    .rsv_ok       (rsv_ok),
    .unlock_state (unlock_state),
    .dwell_time   (dwell_time),
    .iface_ctrl   (iface_ctrl),
    .alarm_matrix (alarm_matrix),
    .error_matrix (error_matrix),
    .led_matrix   (led_matrix)
);

// File: tb/tb_spi_reg_access.sv
module tb_spi_reg_access;
    localparam int HALF = 8;
    localparam logic [15:0] REV = 16'h0102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] status_in = 16'h0000;
    logic [9:0]  dwell_time;
    logic [15:0] iface_ctrl;
    logic [63:0] alarm_matrix, error_matrix, led_matrix;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    spi_reg_access #(.REVISION(REV)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .status_in    (status_in),
        .dwell_time   (dwell_time),
        .iface_ctrl   (iface_ctrl),
        .alarm_matrix (alarm_matrix),
        .error_matrix (error_matrix),
        .led_matrix   (led_matrix)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic wr, input logic [6:0] a, input logic [15:0] d);
        return {wr, a, 8'h00, d};
    endfunction

    task automatic frame(input logic [31:0] cmd, input int nbits, output logic [31:0] resp);
        resp = '0;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 32) ? cmd[31-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            if (i < 32) resp[31-i] = spi_miso;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        logic [31:0] r;
        frame(mk(1'b1, a, d), 32, r);
    endtask

    // read: command frame, then a harmless read of an unmapped address to collect the answer
    task automatic rd(input logic [6:0] a, output logic [31:0] r);
        logic [31:0] dummy;
        frame(mk(1'b0, a, 16'h0000), 32, dummy);
        frame(mk(1'b0, 7'h04, 16'h0000), 32, r);
    endtask

    task automatic unlock();
        wr(7'h00, 16'hA569);
        wr(7'h00, 16'h1248);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R4 miso idle", {63'b0, spi_miso}, 64'd0);
        check("R4 dwell", {54'b0, dwell_time}, 64'd0);
        check("R4 ctrl", {48'b0, iface_ctrl}, 64'd0);
        check("R4 alarm", alarm_matrix, 64'd0);
        check("R4 error", error_matrix, 64'd0);
        check("R4 led", led_matrix, 64'd0);
        rd(7'h00, r);
        check("R4 R8 unlock state after reset", {32'b0, r}, 64'd0);
    endtask

    task automatic t_locked();
        wr(7'h08, 16'hFFFF);
        wr(7'h01, 16'h0005);
        wr(7'h02, 16'h1234);
        check("R9 alarm locked", alarm_matrix, 64'd0);
        check("R9 dwell locked", {54'b0, dwell_time}, 64'd0);
        check("R9 ctrl locked", {48'b0, iface_ctrl}, 64'd0);
        wr(7'h00, 16'hA569);
        wr(7'h02, 16'h1234);
        check("R9 ctrl half unlocked", {48'b0, iface_ctrl}, 64'd0);
    endtask

    task automatic t_unlock();
        logic [31:0] r;
        wr(7'h00, 16'h0000);
        wr(7'h00, 16'hA569);
        rd(7'h00, r);
        check("R5 R8 state after first key", {32'b0, r}, 64'h1);
        wr(7'h00, 16'h1248);
        rd(7'h00, r);
        check("R6 R8 state after second key", {32'b0, r}, 64'h3);
        wr(7'h02, 16'h00A5);
        check("R6 write enabled", {48'b0, iface_ctrl}, 64'h00A5);
    endtask

    task automatic t_cancel();
        logic [31:0] r;
        wr(7'h00, 16'hA569);
        rd(7'h00, r);
        check("R5 first key from open state", {32'b0, r}, 64'h1);
        wr(7'h02, 16'h0F0F);
        check("R9 relocked by first key", {48'b0, iface_ctrl}, 64'h00A5);
        wr(7'h00, 16'h1234);
        rd(7'h00, r);
        check("R7 other value cancels", {32'b0, r}, 64'h0);
        wr(7'h00, 16'h1248);
        rd(7'h00, r);
        check("R7 second key while locked", {32'b0, r}, 64'h0);
        unlock();
        wr(7'h00, 16'h1248);
        rd(7'h00, r);
        check("R7 second key while open", {32'b0, r}, 64'h0);
        unlock();
    endtask

    task automatic t_regs();
        logic [31:0] r;
        wr(7'h01, 16'hFFFF);
        check("R10 dwell output masked", {54'b0, dwell_time}, 64'h3FF);
        rd(7'h01, r);
        check("R10 dwell readback", {32'b0, r}, 64'h3FF);
        wr(7'h02, 16'hBEEF);
        check("R11 ctrl output", {48'b0, iface_ctrl}, 64'hBEEF);
        rd(7'h02, r);
        check("R11 R3 ctrl readback full word", {32'b0, r}, 64'hBEEF);
    endtask

    task automatic t_matrix();
        logic [63:0] exp [3];
        logic [31:0] r;
        for (int i = 0; i < 12; i++) begin
            logic [15:0] v;
            v = 16'(i * 16'h1357) ^ 16'h8421;
            exp[i/4][(i%4)*16 +: 16] = v;
            wr(7'(8 + i), v);
        end
        check("R12 alarm matrix", alarm_matrix, exp[0]);
        check("R12 error matrix", error_matrix, exp[1]);
        check("R12 led matrix", led_matrix, exp[2]);
        for (int i = 0; i < 12; i += 5) begin
            rd(7'(8 + i), r);
            check("R12 matrix word readback", {32'b0, r}, {48'b0, exp[i/4][(i%4)*16 +: 16]});
        end
    endtask

    task automatic t_readonly();
        logic [31:0] r;
        status_in = 16'h5A3C;
        rd(7'h03, r);
        check("R13 status read", {32'b0, r}, 64'h5A3C);
        wr(7'h03, 16'h0000);
        rd(7'h03, r);
        check("R13 status write ignored", {32'b0, r}, 64'h5A3C);
        rd(7'h7F, r);
        check("R13 revision", {32'b0, r}, {48'b0, REV});
        wr(7'h7F, 16'h0000);
        rd(7'h7F, r);
        check("R13 revision write ignored", {32'b0, r}, {48'b0, REV});
        wr(7'h05, 16'hFFFF);
        rd(7'h05, r);
        check("R13 unmapped reads zero", {32'b0, r}, 64'h0);
        rd(7'h40, r);
        check("R13 high unmapped reads zero", {32'b0, r}, 64'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] r;
        wr(7'h02, 16'hBEEF);
        frame(mk(1'b1, 7'h02, 16'h1111) | 32'h0010_0000, 32, r);
        check("R2 reserved write dropped", {48'b0, iface_ctrl}, 64'hBEEF);
        frame(mk(1'b1, 7'h00, 16'h0000) | 32'h0080_0000, 32, r);
        rd(7'h00, r);
        check("R2 reserved key write dropped", {32'b0, r}, 64'h3);
        frame(mk(1'b0, 7'h02, 16'h0000) | 32'h0001_0000, 32, r);
        frame(mk(1'b0, 7'h04, 16'h0000), 32, r);
        check("R2 reserved read answers zero", {32'b0, r}, 64'h0);
    endtask

    task automatic t_response();
        logic [31:0] r;
        frame(mk(1'b1, 7'h02, 16'h2222), 32, r);
        frame(mk(1'b0, 7'h04, 16'h0000), 32, r);
        check("R3 write answers zero", {32'b0, r}, 64'h0);
        frame(mk(1'b0, 7'h02, 16'h0000), 32, r);
        frame(mk(1'b0, 7'h7F, 16'h0000), 32, r);
        check("R3 response follows in next frame", {32'b0, r}, 64'h2222);
        frame(mk(1'b0, 7'h04, 16'h0000), 32, r);
        check("R3 chained read response", {32'b0, r}, {48'b0, REV});
    endtask

    task automatic t_frames();
        logic [31:0] r;
        frame(mk(1'b1, 7'h02, 16'h3333), 40, r);
        check("R1 long frame runs first 32 bits", {48'b0, iface_ctrl}, 64'h3333);
        frame(mk(1'b1, 7'h02, 16'h4444), 20, r);
        check("R1 short frame does nothing", {48'b0, iface_ctrl}, 64'h3333);
        rd(7'h02, r);
        check("R1 counter restarts after short frame", {32'b0, r}, 64'h3333);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_cancel();
        t_regs();
        t_matrix();
        t_readonly();
        t_reserved();
        t_response();
        t_frames();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule